// File: doc/BRIEF.md
# I2C Register-Addressed Transaction Sequencer

This block runs one complete register-addressed transfer on an I2C target by handing a sequence of byte commands to a separate byte-level bus master. A request carries a 7-bit device address, a sub-address of zero up to `SUB_MAX` bytes, an operation code and a data byte count. The sequencer picks the START, repeated START, STOP and acknowledge flags for every byte on its own. Write payload arrives on a valid/ready stream and read payload leaves on a second valid/ready stream.

Before every byte the sequencer waits for the bus to be free. After issuing a byte it waits for the byte engine to report that the byte was sent or received. Each wait is bounded by a timeout built from a poll tick of `TICK_DIV` cycles repeated `TICK_LIMIT` times. A transfer ends with a one-cycle completion pulse, a reset pulse to the byte engine and a held result code. A probe operation checks whether a device answers at an address. New requests are taken only while the sequencer is idle.

Top module: `i2c_xact_seq`

## Requirements
- R1: The first byte of a write or read is `{dev,1'b0}`, issued with START and without the read flag. If the engine reports no acknowledge for it, the sequencer ends with code 3 (missing ACK). Codes: 0 ok, 1 bus busy, 2 transmit timeout, 3 missing ACK, 4 receive timeout, 5 bad parameter.
- R2: Sub-address bytes follow with neither START nor STOP. The most significant byte is sent first: byte `sub_len-1` of `req_sub_i` (bits `8*i+7:8*i` form byte i) down to byte 0. Each of these bytes needs an ACK (code 3 otherwise).
- R3: A read sends a repeated START with `{dev,1'b1}`, then `count` receive commands with command byte 0x00. Every receive command asks for ACK except the last, which carries NACK and STOP. Received bytes leave on the read stream in order and are held while `rd_ready_i` is low.
- R4: A write sends `count` bytes taken in order from the write stream, each needing an ACK. STOP rides on the last byte of the whole transfer: the last data byte, or the last sub-address byte or address byte when the count is zero.
- R5: Operation codes are 0 write, 1 read, 2 probe and 3 reserved. A request with op 3, a read with count 0, or a sub-address length above `SUB_MAX` finishes in the cycle after acceptance with code 5 and issues no command.
- R6: Before each byte the sequencer waits while `eng_busy_i` is high. If the bus stays busy for the timeout, the transfer ends with code 1 and the byte is not issued.
- R7: The timeout is `TICK_DIV*TICK_LIMIT` cycles of one wait. If no transmit completion arrives in time the code is 2. If no receive completion arrives in time the code is 4.
- R8: A probe sends `{dev,1'b1}` with START, then one receive command with NACK and STOP. It reports code 0 only if both steps complete. The probed byte is not put on the read stream.
- R9: `done_o` and `eng_rst_o` pulse for exactly one cycle at every end. `err_o` changes only in that cycle and holds until the next end. `req_ready_o` is high only when idle, and no command or stream handshake is offered while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_op_i | input | 2 | 0 write, 1 read, 2 probe, 3 reserved |
| req_dev_i | input | 7 | Device address |
| req_sub_i | input | 8*SUB_MAX | Sub-address bytes, byte 0 least significant |
| req_sub_len_i | input | SLW | Number of sub-address bytes |
| req_count_i | input | CNT_W | Data byte count |
| wr_valid_i | input | 1 | Write data valid |
| wr_ready_o | output | 1 | Write data taken |
| wr_data_i | input | 8 | Write data byte |
| rd_valid_o | output | 1 | Read data valid |
| rd_ready_i | input | 1 | Read data accepted |
| rd_data_o | output | 8 | Read data byte |
| cmd_valid_o | output | 1 | Byte command strobe to the engine |
| cmd_data_o | output | 8 | Byte to transmit (0x00 for receive) |
| cmd_rd_o | output | 1 | Receive command |
| cmd_start_o | output | 1 | Generate START before the byte |
| cmd_stop_o | output | 1 | Generate STOP after the byte |
| cmd_nack_o | output | 1 | Answer the received byte with NACK |
| eng_busy_i | input | 1 | Bus held by another master |
| eng_tx_done_i | input | 1 | Transmit completion pulse |
| eng_ack_i | input | 1 | Target acknowledged, valid with tx done |
| eng_rx_done_i | input | 1 | Receive completion pulse |
| eng_rx_data_i | input | 8 | Received byte, valid with rx done |
| eng_rst_o | output | 1 | Byte engine reset pulse |
| done_o | output | 1 | Completion pulse |
| err_o | output | 3 | Result code |

## Verification
The bench builds the sequencer with `SUB_MAX=4`, `CNT_W=4`, `TICK_DIV=3` and `TICK_LIMIT=6`. With these values every timeout path finishes in about 18 cycles, so bus-busy, dropped-transmit and dropped-receive cases run quickly. Sub-address lengths of 5 to 7 fit in the length port and exercise the rejection path. The responder model stalls each byte by a random 1 to 6 cycles, and the streams apply random backpressure. Together these check the flag sequence of every transfer shape against a list computed in the bench from the request.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_READ = 2'd1, OP_PROBE = 2'd2, OP_RSVD = 2'd3} op_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BUSY   = 3'd1,
    ERR_TX_TMO = 3'd2,
    ERR_NO_ACK = 3'd3,
    ERR_RX_TMO = 3'd4,
    ERR_PARAM  = 3'd5
  } err_e;

  typedef enum logic [1:0] {PH_DADDR, PH_SUB, PH_RADDR, PH_DATA} ph_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT_BUS, S_ISSUE, S_WAIT_TX, S_WAIT_RX, S_PUSH, S_FINISH
  } st_e;

  typedef struct packed {
    logic       rd;
    logic       start;
    logic       stop;
    logic       nack;
    logic [7:0] data;
  } cmd_t;
endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int TICK_DIV   = 2000,
  parameter int TICK_LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int LW = $clog2(TICK_LIMIT + 1);

  logic [DW-1:0] pre_q;
  logic [LW-1:0] polls_q;

  assign expired_o = (polls_q == LW'(TICK_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (!run_i || clr_i) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (!expired_o) begin
      if (pre_q == DW'(TICK_DIV - 1)) begin
        pre_q   <= '0;
        polls_q <= polls_q + LW'(1);
      end else begin
        pre_q <= pre_q + DW'(1);
      end
    end
  end

  AST_TMR_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q <= LW'(TICK_LIMIT)); // R7
  AST_TMR_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !expired_o); // R7
endmodule

// File: rtl/i2c_seq_plan.sv
module i2c_seq_plan
  import i2c_seq_pkg::*;
#(
  parameter int SUB_MAX = 4,
  parameter int CNT_W   = 8,
  localparam int SLW    = $clog2(SUB_MAX + 1),
  localparam int IW     = (SUB_MAX > 1) ? $clog2(SUB_MAX) : 1
) (
  input  op_e                  op_i,
  input  logic [6:0]           dev_i,
  input  logic [8*SUB_MAX-1:0] sub_i,
  input  logic [SLW-1:0]       sub_len_i,
  input  ph_e                  ph_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [CNT_W-1:0]     rem_i,
  input  logic [7:0]           wbyte_i,
  output cmd_t                 cmd_o,
  output ph_e                  nxt_ph_o,
  output logic [IW-1:0]        nxt_idx_o,
  output logic                 last_o
);
  logic [7:0] sub_b [SUB_MAX];

  for (genvar g = 0; g < SUB_MAX; g++) begin : g_sub
    assign sub_b[g] = sub_i[8*g +: 8];
  end

  logic is_wr, rem_zero, rem_one;
  assign is_wr    = (op_i == OP_WRITE);
  assign rem_zero = (rem_i == '0);
  assign rem_one  = (rem_i == CNT_W'(1));

  always_comb begin
    cmd_o     = '0;
    nxt_ph_o  = ph_i;
    nxt_idx_o = idx_i;
    last_o    = 1'b0;
    unique case (ph_i)
      PH_DADDR: begin
        cmd_o.data  = {dev_i, 1'b0};
        cmd_o.start = 1'b1;
        cmd_o.stop  = is_wr && (sub_len_i == '0) && rem_zero;
        last_o      = cmd_o.stop;
        if (sub_len_i != '0) begin
          nxt_ph_o  = PH_SUB;
          nxt_idx_o = IW'(sub_len_i - SLW'(1));
        end else begin
          nxt_ph_o = is_wr ? PH_DATA : PH_RADDR;
        end
      end
      PH_SUB: begin
        cmd_o.data = sub_b[idx_i];
        cmd_o.stop = is_wr && (idx_i == '0) && rem_zero;
        last_o     = cmd_o.stop;
        if (idx_i != '0) nxt_idx_o = idx_i - IW'(1);
        else nxt_ph_o = is_wr ? PH_DATA : PH_RADDR;
      end
      PH_RADDR: begin
        cmd_o.data  = {dev_i, 1'b1};
        cmd_o.start = 1'b1;
        nxt_ph_o    = PH_DATA;
      end
      default: begin
        if (is_wr) begin
          cmd_o.data = wbyte_i;
        end else begin
          cmd_o.rd   = 1'b1;
          cmd_o.nack = rem_one;
        end
        cmd_o.stop = rem_one;
        last_o     = rem_one;
      end
    endcase
  end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_seq_pkg::*;
#(
  parameter int SUB_MAX    = 4,
  parameter int CNT_W      = 8,
  parameter int TICK_DIV   = 2000,
  parameter int TICK_LIMIT = 1000,
  localparam int SLW       = $clog2(SUB_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [1:0]           req_op_i,
  input  logic [6:0]           req_dev_i,
  input  logic [8*SUB_MAX-1:0] req_sub_i,
  input  logic [SLW-1:0]       req_sub_len_i,
  input  logic [CNT_W-1:0]     req_count_i,
  input  logic                 wr_valid_i,
  output logic                 wr_ready_o,
  input  logic [7:0]           wr_data_i,
  output logic                 rd_valid_o,
  input  logic                 rd_ready_i,
  output logic [7:0]           rd_data_o,
  output logic                 cmd_valid_o,
  output logic [7:0]           cmd_data_o,
  output logic                 cmd_rd_o,
  output logic                 cmd_start_o,
  output logic                 cmd_stop_o,
  output logic                 cmd_nack_o,
  input  logic                 eng_busy_i,
  input  logic                 eng_tx_done_i,
  input  logic                 eng_ack_i,
  input  logic                 eng_rx_done_i,
  input  logic [7:0]           eng_rx_data_i,
  output logic                 eng_rst_o,
  output logic                 done_o,
  output logic [2:0]           err_o
);
  localparam int IW = (SUB_MAX > 1) ? $clog2(SUB_MAX) : 1;

  st_e                  st_q, st_d, route;
  err_e                 err_q, err_d;
  op_e                  op_q, req_op;
  ph_e                  ph_q, nxt_ph;
  logic [6:0]           dev_q;
  logic [8*SUB_MAX-1:0] sub_q;
  logic [SLW-1:0]       sub_len_q;
  logic [IW-1:0]        idx_q, nxt_idx;
  logic [CNT_W-1:0]     rem_q;
  logic [7:0]           wbuf_q, rbuf_q;
  logic                 last, adv, accept, req_bad, tmo, tmr_run;
  cmd_t                 cmd;

  assign req_op  = op_e'(req_op_i);
  assign req_bad = (req_op == OP_RSVD)
                || (req_op == OP_READ && req_count_i == '0)
                || (req_sub_len_i > SLW'(SUB_MAX));

  i2c_seq_plan #(.SUB_MAX(SUB_MAX), .CNT_W(CNT_W)) u_plan (
    .op_i(op_q), .dev_i(dev_q), .sub_i(sub_q), .sub_len_i(sub_len_q),
    .ph_i(ph_q), .idx_i(idx_q), .rem_i(rem_q), .wbyte_i(wbuf_q),
    .cmd_o(cmd), .nxt_ph_o(nxt_ph), .nxt_idx_o(nxt_idx), .last_o(last)
  );

  assign tmr_run = (st_q == S_WAIT_BUS) || (st_q == S_WAIT_TX) || (st_q == S_WAIT_RX);

  i2c_seq_timer #(.TICK_DIV(TICK_DIV), .TICK_LIMIT(TICK_LIMIT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_run), .clr_i(st_d != st_q),
    .expired_o(tmo)
  );

  always_comb begin
    st_d   = st_q;
    err_d  = err_q;
    adv    = 1'b0;
    accept = 1'b0;
    route  = (nxt_ph == PH_DATA && op_q == OP_WRITE) ? S_FETCH : S_WAIT_BUS;
    unique case (st_q)
      S_IDLE: if (req_valid_i) begin
        accept = 1'b1;
        if (req_bad) begin
          st_d  = S_FINISH;
          err_d = ERR_PARAM;
        end else begin
          st_d = S_WAIT_BUS;
        end
      end
      S_FETCH: if (wr_valid_i) st_d = S_WAIT_BUS;
      S_WAIT_BUS: begin
        if (!eng_busy_i) st_d = S_ISSUE;
        else if (tmo) begin
          st_d  = S_FINISH;
          err_d = ERR_BUSY;
        end
      end
      S_ISSUE: st_d = cmd.rd ? S_WAIT_RX : S_WAIT_TX;
      S_WAIT_TX: begin
        if (eng_tx_done_i) begin
          if (!eng_ack_i) begin
            st_d  = S_FINISH;
            err_d = ERR_NO_ACK;
          end else begin
            adv = 1'b1;
            if (last) begin
              st_d  = S_FINISH;
              err_d = ERR_NONE;
            end else st_d = route;
          end
        end else if (tmo) begin
          st_d  = S_FINISH;
          err_d = ERR_TX_TMO;
        end
      end
      S_WAIT_RX: begin
        if (eng_rx_done_i) begin
          if (op_q == OP_PROBE) begin
            adv = 1'b1;
            if (last) begin
              st_d  = S_FINISH;
              err_d = ERR_NONE;
            end else st_d = route;
          end else st_d = S_PUSH;
        end else if (tmo) begin
          st_d  = S_FINISH;
          err_d = ERR_RX_TMO;
        end
      end
      S_PUSH: if (rd_ready_i) begin
        adv = 1'b1;
        if (last) begin
          st_d  = S_FINISH;
          err_d = ERR_NONE;
        end else st_d = route;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      err_q     <= ERR_NONE;
      op_q      <= OP_WRITE;
      ph_q      <= PH_DADDR;
      dev_q     <= '0;
      sub_q     <= '0;
      sub_len_q <= '0;
      idx_q     <= '0;
      rem_q     <= '0;
      wbuf_q    <= '0;
      rbuf_q    <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (accept) begin
        op_q      <= req_op;
        dev_q     <= req_dev_i;
        sub_q     <= req_sub_i;
        sub_len_q <= req_sub_len_i;
        idx_q     <= '0;
        if (req_op == OP_PROBE) begin
          ph_q  <= PH_RADDR;
          rem_q <= CNT_W'(1);
        end else begin
          ph_q  <= PH_DADDR;
          rem_q <= req_count_i;
        end
      end
      if (adv) begin
        ph_q  <= nxt_ph;
        idx_q <= nxt_idx;
        if (ph_q == PH_DATA) rem_q <= rem_q - CNT_W'(1);
      end
      if (st_q == S_FETCH && wr_valid_i) wbuf_q <= wr_data_i;
      if (st_q == S_WAIT_RX && eng_rx_done_i) rbuf_q <= eng_rx_data_i;
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign wr_ready_o  = (st_q == S_FETCH);
  assign rd_valid_o  = (st_q == S_PUSH);
  assign rd_data_o   = rbuf_q;
  assign cmd_valid_o = (st_q == S_ISSUE);
  assign cmd_data_o  = cmd.data;
  assign cmd_rd_o    = cmd.rd;
  assign cmd_start_o = cmd.start;
  assign cmd_stop_o  = cmd.stop;
  assign cmd_nack_o  = cmd.nack;
  assign done_o      = (st_q == S_FINISH);
  assign eng_rst_o   = (st_q == S_FINISH);
  assign err_o       = err_q;

  AST_START_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_start_o |-> !cmd_rd_o); // R1
  AST_NACK_WITH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_nack_o |-> cmd_stop_o && cmd_rd_o); // R3
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)); // R3
  AST_ISSUE_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !$past(eng_busy_i)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o); // R9
  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o && !wr_ready_o && !rd_valid_o); // R9
endmodule

// File: tb/tb_i2c_xact_seq.sv
`timescale 1ns/100ps
module tb_i2c_xact_seq;
  localparam int SUB_MAX = 4, CNT_W = 4, TICK_DIV = 3, TICK_LIMIT = 6;
  localparam int TMO = TICK_DIV * TICK_LIMIT;
  localparam int SLW = $clog2(SUB_MAX + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [6:0] req_dev = 0;
  logic [8*SUB_MAX-1:0] req_sub = 0;
  logic [SLW-1:0] req_sub_len = 0;
  logic [CNT_W-1:0] req_count = 0;
  logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic cmd_valid, cmd_rd, cmd_start, cmd_stop, cmd_nack;
  logic [7:0] cmd_data;
  logic eng_busy = 0, eng_tx_done = 0, eng_ack = 1, eng_rx_done = 0;
  logic [7:0] eng_rx_data = 0;
  logic eng_rst, done;
  logic [2:0] err;

  i2c_xact_seq #(.SUB_MAX(SUB_MAX), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .TICK_LIMIT(TICK_LIMIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_dev_i(req_dev), .req_sub_i(req_sub), .req_sub_len_i(req_sub_len),
    .req_count_i(req_count), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_rd_o(cmd_rd), .cmd_start_o(cmd_start),
    .cmd_stop_o(cmd_stop), .cmd_nack_o(cmd_nack), .eng_busy_i(eng_busy),
    .eng_tx_done_i(eng_tx_done), .eng_ack_i(eng_ack), .eng_rx_done_i(eng_rx_done),
    .eng_rx_data_i(eng_rx_data), .eng_rst_o(eng_rst), .done_o(done), .err_o(err)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // observers at the clock edge
  logic [11:0] log_mem [2048];
  logic [7:0]  got_mem [2048];
  logic [7:0]  wr_src  [2048];
  logic [7:0]  exp_rx  [2048];
  int log_n = 0, got_n = 0, wr_ptr = 0, wr_end = 0, rx_n = 0, seen = 0;
  int flt_kind = 0, flt_at = -1;

  always @(posedge clk) begin
    if (cmd_valid && log_n < 2048) begin
      log_mem[log_n] <= {cmd_rd, cmd_start, cmd_stop, cmd_nack, cmd_data};
      log_n <= log_n + 1;
    end
    if (rd_valid && rd_ready && got_n < 2048) begin
      got_mem[got_n] <= rd_data;
      got_n <= got_n + 1;
    end
    if (wr_valid && wr_ready) wr_ptr <= wr_ptr + 1;
  end

  initial forever begin
    @(negedge clk);
    wr_valid = (wr_ptr < wr_end) && ($urandom % 4 != 0);
    wr_data  = wr_src[wr_ptr % 2048];
    rd_ready = ($urandom % 3 != 0);
  end

  // byte engine model
  initial begin : eng_model
    int me;
    bit rd;
    forever begin
      @(negedge clk);
      eng_tx_done = 0;
      eng_rx_done = 0;
      if (cmd_valid) begin
        me = seen;
        rd = cmd_rd;
        seen++;
        if (!(flt_kind == 2 && me == flt_at)) begin
          repeat (1 + $urandom % 6) @(negedge clk);
          if (rd) begin
            eng_rx_data = 8'($urandom);
            exp_rx[rx_n % 2048] = eng_rx_data;
            rx_n++;
            eng_rx_done = 1;
          end else begin
            eng_ack = !(flt_kind == 1 && me == flt_at);
            eng_tx_done = 1;
          end
        end
      end
    end
  end

  logic [11:0] exp_cmd [64];
  int exp_n;

  task automatic push(input bit r, input bit s, input bit p, input bit n, input logic [7:0] d);
    exp_cmd[exp_n] = {r, s, p, n, d};
    exp_n++;
  endtask

  task automatic build_exp(input int op, input logic [6:0] dev, input logic [31:0] sub,
                           input int slen, input int cnt, input int wb);
    exp_n = 0;
    if (op == 2) begin
      push(0, 1, 0, 0, {dev, 1'b1});
      push(1, 0, 1, 1, 8'h00);
    end else begin
      push(0, 1, (op == 0 && slen == 0 && cnt == 0), 0, {dev, 1'b0});
      for (int j = slen - 1; j >= 0; j--)
        push(0, 0, (op == 0 && j == 0 && cnt == 0), 0, sub[8*j +: 8]);
      if (op == 1) begin
        push(0, 1, 0, 0, {dev, 1'b1});
        for (int i = 0; i < cnt; i++) push(1, 0, i == cnt - 1, i == cnt - 1, 8'h00);
      end else begin
        for (int i = 0; i < cnt; i++) push(0, 0, i == cnt - 1, 0, wr_src[(wb + i) % 2048]);
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // fkind: 0 none, 1 nack at cmd fat, 2 no response at cmd fat
  task automatic run_txn(input int op, input logic [6:0] dev, input logic [31:0] sub,
                         input int slen, input int cnt, input int fkind, input int fat, input bit busy);
    int wb, lb, gb, rb, cyc, exp_err, ncmp, ev;
    bit pbad;
    wb = wr_ptr; lb = log_n; gb = got_n; rb = rx_n;
    for (int i = 0; i < cnt; i++) wr_src[(wb + i) % 2048] = 8'($urandom);
    pbad = (op == 3) || (op == 1 && cnt == 0) || (slen > SUB_MAX);
    wr_end = (op == 0 && !pbad && !busy) ? wb + cnt : wb;
    build_exp(op, dev, sub, slen, cnt, wb);
    flt_kind = fkind;
    flt_at = seen + fat;
    eng_busy = busy;
    exp_err = 0; ncmp = exp_n;
    if (pbad) begin exp_err = 5; ncmp = 0; end
    else if (busy) begin exp_err = 1; ncmp = 0; end
    else if (fkind == 1 && fat < exp_n && !exp_cmd[fat][11]) begin exp_err = 3; ncmp = fat + 1; end
    else if (fkind == 2 && fat < exp_n) begin exp_err = exp_cmd[fat][11] ? 4 : 2; ncmp = fat + 1; end
    req_op = 2'(op); req_dev = dev; req_sub = sub; req_sub_len = SLW'(slen); req_count = CNT_W'(cnt);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9 ready low while busy", int'(req_ready), 0);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R9 done arrives", int'(done), 1);
    chk(eng_rst, "R9 engine reset with done", int'(eng_rst), 1);
    ev = int'(err);
    if (pbad) chk(cyc == 0, "R5 immediate reject", cyc, 0);
    if (busy) chk(cyc >= TMO && cyc <= TMO + 2, "R6 R7 busy timeout window", cyc, TMO + 1);
    chk(ev == exp_err, "R1 R5 R6 R7 result code", ev, exp_err);
    @(negedge clk);
    chk(!done && req_ready && int'(err) == ev, "R9 pulse and hold", {int'(done), int'(req_ready)}, 1);
    chk(log_n - lb == ncmp, "R1 R2 R3 R4 R8 command count", log_n - lb, ncmp);
    for (int i = 0; i < ncmp && i < log_n - lb; i++)
      if (log_mem[(lb + i) % 2048] != exp_cmd[i])
        chk(0, "R1 R2 R3 R4 R8 command flags", int'(log_mem[(lb + i) % 2048]), int'(exp_cmd[i]));
    if (op == 1 && exp_err == 0) begin
      chk(got_n - gb == cnt, "R3 read count", got_n - gb, cnt);
      for (int i = 0; i < cnt; i++)
        if (got_mem[(gb + i) % 2048] != exp_rx[(rb + i) % 2048])
          chk(0, "R3 read data", int'(got_mem[(gb + i) % 2048]), int'(exp_rx[(rb + i) % 2048]));
    end
    if (op == 2) chk(got_n == gb, "R8 probe not streamed", got_n - gb, 0);
    if (op == 0 && exp_err == 0) chk(wr_ptr - wb == cnt, "R4 write bytes taken", wr_ptr - wb, cnt);
    eng_busy = 0;
    flt_kind = 0;
    @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !cmd_valid && err == 0, "R9 reset state", int'(err), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_ready && !wr_ready && !rd_valid, "R9 idle after reset", int'(req_ready), 1);

    run_txn(0, 7'h50, 32'h0000_1234, 2, 3, 0, 0, 0);   // R1 R2 R4 write
    run_txn(1, 7'h21, 32'h0000_00a5, 1, 4, 0, 0, 0);   // R3 read
    run_txn(1, 7'h3c, 32'h0, 0, 1, 0, 0, 0);           // R3 single NACK read
    run_txn(0, 7'h11, 32'h0, 0, 0, 0, 0, 0);           // R4 stop on address
    run_txn(0, 7'h12, 32'h0000_beef, 2, 0, 0, 0, 0);   // R4 stop on last sub byte
    run_txn(1, 7'h7f, 32'h0102_0304, 4, 2, 0, 0, 0);   // R2 four sub bytes MSB first
    run_txn(2, 7'h48, 32'h0, 0, 0, 0, 0, 0);           // R8 probe present
    run_txn(2, 7'h48, 32'h0, 0, 0, 1, 0, 0);           // R8 probe absent
    run_txn(2, 7'h48, 32'h0, 0, 0, 2, 1, 0);           // R8 R7 probe rx timeout
    run_txn(1, 7'h20, 32'h0, 0, 0, 0, 0, 0);           // R5 read count 0
    run_txn(3, 7'h20, 32'h0, 0, 2, 0, 0, 0);           // R5 reserved op
    run_txn(0, 7'h20, 32'h0, 5, 2, 0, 0, 0);           // R5 sub length too large
    run_txn(0, 7'h33, 32'h0000_0042, 1, 2, 0, 0, 1);   // R6 bus busy
    run_txn(0, 7'h33, 32'h0000_4455, 2, 2, 1, 1, 0);   // R2 nack on sub byte
    run_txn(1, 7'h33, 32'h0000_0042, 1, 2, 1, 2, 0);   // R3 nack on repeated start
    run_txn(0, 7'h34, 32'h0, 0, 2, 1, 0, 0);           // R1 nack on address
    run_txn(0, 7'h35, 32'h0, 0, 2, 2, 0, 0);           // R7 tx timeout
    run_txn(1, 7'h36, 32'h0, 0, 3, 2, 2, 0);           // R7 rx timeout

    for (int t = 0; t < 60; t++) begin
      int op, slen, cnt, fk, fa;
      op   = $urandom % 3;
      slen = $urandom % (SUB_MAX + 1);
      cnt  = $urandom % 7;
      fk   = ($urandom % 4 == 0) ? 1 + $urandom % 2 : 0;
      fa   = $urandom % 10;
      run_txn(op, 7'($urandom), $urandom, slen, cnt, fk, fa, ($urandom % 12 == 0));
    end
    finish_run();
  end
endmodule